// File: doc/BRIEF.md
# SAT Decision Sequencer

This block is the top-level controller of a hardware Boolean satisfiability solver. It takes decisions one variable at a time in a fixed order, the variable with identification tag k being decided at decision level k. Tags are handed out offline so that the variables that occur most often get the lowest tags. After each decision it waits until the clause banks stop reporting new implications. It then either moves on to the next tag or, when a conflict has been flagged, runs conflict analysis and a non-chronological backtrack.

A fresh decision always drives value 0. Each level keeps a flag that records whether its decision has already been flipped. A backtrack goes to the level chosen by the base cells, capped at the current level. If that level was already flipped, it goes to the nearest lower level that was not. The decision at the target level is then reapplied as value 1 and marked as forced, and the flags of every deeper level are cleared. When the last tag has been decided with no conflict, the block reports satisfiable. When a conflict finds no unflipped level at or below the limit, it reports unsatisfiable.

The clause banks, the communication tree and the learned-clause storage sit outside this block. It only drives their control strobes and reads back the three aggregated status signals.

Top module: `sat_decide_ctrl`

## Requirements
- R1: After reset, and while idle with start low, done_o, asg_valid_o, refresh_o, clr_all_o, clr_above_o, ident_o and wr_o are all low.
- R2: The cycle after start_i is seen high in idle is a refresh cycle with refresh_o and clr_all_o both high. The cycle after that assigns tag 0.
- R3: An assignment cycle raises asg_valid_o for exactly one cycle, with asg_var_o and asg_lvl_o equal to the current level. A level that has not been flipped drives asg_val_o=0 and asg_forced_o=0.
- R4: In the wait state, while impl_pend_i is high and conflict_i is low, the block stays put: no assignment, no done and no analysis. The first wait cycle with both inputs low leads, one cycle later, to the next assignment.
- R5: A quiet wait cycle at level NUM_VARS-1 leads, one cycle later, to done_o=1 with sat_o=1.
- R6: conflict_i high in a wait cycle takes priority over impl_pend_i. The next cycle is an analysis cycle with ident_o and wr_o high and no assignment.
- R7: When a target exists, the cycle after analysis raises clr_above_o with clr_lvl_o set to the target. The target is the highest unflipped level not above min(bck_lvl_i, current level), with bck_lvl_i sampled during analysis.
- R8: The cycle after clr_above_o is a precharge cycle: refresh_o is high and clr_all_o is low. The next cycle reassigns the target tag with asg_val_o=1 and asg_forced_o=1.
- R9: A backtrack clears the flipped flag of every level above the target, so later decisions at those levels are fresh again (value 0, not forced).
- R10: If no unflipped level exists at or below the limit, the cycle after analysis shows done_o=1 with sat_o=0, and clr_above_o stays low.
- R11: done_o lasts one cycle. The block then stays quiet until start_i goes low, and returns to idle in the cycle after that. A new start begins with all flags cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Run request; level sensitive |
| impl_pend_i | input | 1 | OR of all new-implication pulses from the base cells |
| conflict_i | input | 1 | A conflict has been detected in the clause banks |
| bck_lvl_i | input | LVL_W | Backtrack level resolved by the base cells |
| done_o | output | 1 | One-cycle completion strobe |
| sat_o | output | 1 | Result with done_o: 1 satisfiable, 0 unsatisfiable |
| asg_valid_o | output | 1 | Assignment drive strobe |
| asg_var_o | output | VAR_W | Tag of the variable being assigned |
| asg_lvl_o | output | LVL_W | Decision level of the assignment |
| asg_val_o | output | 1 | Assigned value |
| asg_forced_o | output | 1 | Assignment is a forced (flipped) decision |
| refresh_o | output | 1 | Precharge/predischarge all shared lines |
| clr_all_o | output | 1 | Clear every base cell |
| clr_above_o | output | 1 | Clear base cells whose level exceeds clr_lvl_o |
| clr_lvl_o | output | LVL_W | Backtrack target used by clr_above_o |
| ident_o | output | 1 | Identify the literals of the learned clause |
| wr_o | output | 1 | Write the learned clause |

## Verification
Every output decodes the registered state, so each result appears exactly one clock after the cycle that caused it. The refresh comes one cycle after start. Analysis follows one cycle after a conflicting wait cycle, and the clear or the unsatisfiable strobe one cycle after analysis. Precharge comes one cycle after the clear, and the forced reassignment one cycle after that. The bench changes inputs only on the falling edge and samples outputs on the next falling edge. Each task walks the state sequence one half-period pair at a time, so every check lands in the single cycle where the result is due. Pending implications are held for several cycles to confirm that nothing advances early.

// File: rtl/sat_dec_pkg.sv
package sat_dec_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REFRESH,
    ST_ASSIGN,
    ST_WAIT,
    ST_ANALYZE,
    ST_EXECUTE,
    ST_PRECHG,
    ST_SAT,
    ST_UNSAT,
    ST_HOLD
  } dec_state_e;

endpackage

// File: rtl/sat_dec_fsm.sv
module sat_dec_fsm
  import sat_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       impl_pend_i,
  input  logic       conflict_i,
  input  logic       last_lvl_i,
  input  logic       tgt_found_i,
  output dec_state_e state_o
);

  dec_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_REFRESH;
      ST_REFRESH: state_d = ST_ASSIGN;
      ST_ASSIGN:  state_d = ST_WAIT;
      ST_WAIT: begin
        if (conflict_i)       state_d = ST_ANALYZE;
        else if (impl_pend_i) state_d = ST_WAIT;
        else if (last_lvl_i)  state_d = ST_SAT;
        else                  state_d = ST_ASSIGN;
      end
      ST_ANALYZE: state_d = tgt_found_i ? ST_EXECUTE : ST_UNSAT;
      ST_EXECUTE: state_d = ST_PRECHG;
      ST_PRECHG:  state_d = ST_ASSIGN;
      ST_SAT:     state_d = ST_HOLD;
      ST_UNSAT:   state_d = ST_HOLD;
      ST_HOLD:    if (!start_i) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/sat_dec_levels.sv
module sat_dec_levels
  import sat_dec_pkg::*;
#(
  parameter int NUM_VARS = 16,
  parameter int LVL_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dec_state_e       state_i,
  input  logic             advance_i,
  input  logic [LVL_W-1:0] bck_lvl_i,
  output logic [LVL_W-1:0] cur_lvl_o,
  output logic             last_o,
  output logic             flip_cur_o,
  output logic             tgt_found_o,
  output logic [LVL_W-1:0] tgt_lvl_o
);

  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(NUM_VARS - 1);

  logic [LVL_W-1:0]    lvl_q;
  logic [LVL_W-1:0]    tgt_q;
  logic [NUM_VARS-1:0] flip_q;
  logic [LVL_W-1:0]    limit;
  logic [LVL_W:0]      pick;

  // Smaller of the requested backtrack level and the current level.
  function automatic logic [LVL_W-1:0] clamp_lvl(input logic [LVL_W-1:0] req,
                                                 input logic [LVL_W-1:0] cur);
    return (req < cur) ? req : cur;
  endfunction

  // Highest level not above lim whose decision is still unflipped.
  // Bit LVL_W is the found flag, the rest is the level.
  function automatic logic [LVL_W:0] pick_target(input logic [NUM_VARS-1:0] fl,
                                                 input logic [LVL_W-1:0]    lim);
    logic [LVL_W:0] res;
    res = '0;
    for (int i = 0; i < NUM_VARS; i++) begin
      if (LVL_W'(i) <= lim && !fl[i]) res = {1'b1, LVL_W'(i)};
    end
    return res;
  endfunction

  // Flipped flag of the level being decided.
  function automatic logic flag_at(input logic [NUM_VARS-1:0] fl,
                                   input logic [LVL_W-1:0]    at);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NUM_VARS; i++) begin
      if (LVL_W'(i) == at) r = fl[i];
    end
    return r;
  endfunction

  assign limit = clamp_lvl(bck_lvl_i, lvl_q);
  assign pick  = pick_target(flip_q, limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else if (state_i == ST_REFRESH) begin
      lvl_q <= '0;
    end else if (advance_i) begin
      lvl_q <= lvl_q + 1'b1;
    end else if (state_i == ST_EXECUTE) begin
      lvl_q <= tgt_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      tgt_q <= '0;
    else if (state_i == ST_ANALYZE)  tgt_q <= pick[LVL_W-1:0];
  end

  for (genvar g = 0; g < NUM_VARS; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flip_q[g] <= 1'b0;
      end else if (state_i == ST_REFRESH) begin
        flip_q[g] <= 1'b0;
      end else if (state_i == ST_EXECUTE) begin
        if (LVL_W'(g) > tgt_q)       flip_q[g] <= 1'b0;
        else if (LVL_W'(g) == tgt_q) flip_q[g] <= 1'b1;
      end
    end
  end

  assign cur_lvl_o   = lvl_q;
  assign last_o      = (lvl_q == LAST_LVL);
  assign flip_cur_o  = flag_at(flip_q, lvl_q);
  assign tgt_found_o = pick[LVL_W];
  assign tgt_lvl_o   = tgt_q;

endmodule

// File: rtl/sat_decide_ctrl.sv
module sat_decide_ctrl
  import sat_dec_pkg::*;
#(
  parameter int NUM_VARS = 16,
  parameter int LVL_W    = 5,
  localparam int VAR_W   = $clog2(NUM_VARS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             impl_pend_i,
  input  logic             conflict_i,
  input  logic [LVL_W-1:0] bck_lvl_i,
  output logic             done_o,
  output logic             sat_o,
  output logic             asg_valid_o,
  output logic [VAR_W-1:0] asg_var_o,
  output logic [LVL_W-1:0] asg_lvl_o,
  output logic             asg_val_o,
  output logic             asg_forced_o,
  output logic             refresh_o,
  output logic             clr_all_o,
  output logic             clr_above_o,
  output logic [LVL_W-1:0] clr_lvl_o,
  output logic             ident_o,
  output logic             wr_o
);

  dec_state_e       state;
  logic [LVL_W-1:0] cur_lvl;
  logic [LVL_W-1:0] tgt_lvl;
  logic             last_lvl;
  logic             flip_cur;
  logic             tgt_found;

  // Named internal events, also seen by the bound checker.
  logic in_wait;
  logic in_assign;
  logic advance;

  assign in_wait   = (state == ST_WAIT);
  assign in_assign = (state == ST_ASSIGN);
  assign advance   = in_wait && !conflict_i && !impl_pend_i && !last_lvl;

  sat_dec_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .impl_pend_i (impl_pend_i),
    .conflict_i  (conflict_i),
    .last_lvl_i  (last_lvl),
    .tgt_found_i (tgt_found),
    .state_o     (state)
  );

  sat_dec_levels #(
    .NUM_VARS (NUM_VARS),
    .LVL_W    (LVL_W)
  ) u_levels (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_i     (state),
    .advance_i   (advance),
    .bck_lvl_i   (bck_lvl_i),
    .cur_lvl_o   (cur_lvl),
    .last_o      (last_lvl),
    .flip_cur_o  (flip_cur),
    .tgt_found_o (tgt_found),
    .tgt_lvl_o   (tgt_lvl)
  );

  assign asg_valid_o  = in_assign;
  assign asg_var_o    = cur_lvl[VAR_W-1:0];
  assign asg_lvl_o    = cur_lvl;
  assign asg_val_o    = in_assign && flip_cur;
  assign asg_forced_o = in_assign && flip_cur;

  assign refresh_o    = (state == ST_REFRESH) || (state == ST_PRECHG);
  assign clr_all_o    = (state == ST_REFRESH);
  assign clr_above_o  = (state == ST_EXECUTE);
  assign clr_lvl_o    = tgt_lvl;
  assign ident_o      = (state == ST_ANALYZE);
  assign wr_o         = (state == ST_ANALYZE);
  assign done_o       = (state == ST_SAT) || (state == ST_UNSAT);
  assign sat_o        = (state == ST_SAT);

endmodule

// File: rtl/sat_decide_chk.sv
module sat_decide_chk #(
  parameter int LVL_W = 5,
  parameter int VAR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             impl_pend_i,
  input logic             conflict_i,
  input logic             in_wait,
  input logic [LVL_W-1:0] cur_lvl,
  input logic             done_o,
  input logic             sat_o,
  input logic             asg_valid_o,
  input logic [VAR_W-1:0] asg_var_o,
  input logic             asg_val_o,
  input logic             asg_forced_o,
  input logic             refresh_o,
  input logic             clr_all_o,
  input logic             clr_above_o,
  input logic [LVL_W-1:0] clr_lvl_o,
  input logic             ident_o,
  input logic             wr_o
);

  a_r2_refresh_then_first: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all_o |=> asg_valid_o && asg_var_o == '0);

  a_r3_assign_single: assert property (@(posedge clk) disable iff (!rst_n)
    asg_valid_o |=> !asg_valid_o);

  a_r4_hold_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait && impl_pend_i && !conflict_i |=> !asg_valid_o && !done_o && !ident_o);

  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r6_conflict_to_analyze: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait && conflict_i |=> ident_o && wr_o && !asg_valid_o);

  a_r7_clear_not_above_level: assert property (@(posedge clk) disable iff (!rst_n)
    clr_above_o |-> clr_lvl_o <= cur_lvl);

  a_r8_exec_then_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    clr_above_o |=> refresh_o && !clr_all_o);

  a_r8_forced_is_one: assert property (@(posedge clk) disable iff (!rst_n)
    asg_forced_o |-> asg_val_o && asg_valid_o);

  a_r10_unsat_after_analyze: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !sat_o |-> $past(ident_o));

endmodule

bind sat_decide_ctrl sat_decide_chk #(
  .LVL_W (LVL_W),
  .VAR_W (VAR_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .impl_pend_i  (impl_pend_i),
  .conflict_i   (conflict_i),
  .in_wait      (in_wait),
  .cur_lvl      (cur_lvl),
  .done_o       (done_o),
  .sat_o        (sat_o),
  .asg_valid_o  (asg_valid_o),
  .asg_var_o    (asg_var_o),
  .asg_val_o    (asg_val_o),
  .asg_forced_o (asg_forced_o),
  .refresh_o    (refresh_o),
  .clr_all_o    (clr_all_o),
  .clr_above_o  (clr_above_o),
  .clr_lvl_o    (clr_lvl_o),
  .ident_o      (ident_o),
  .wr_o         (wr_o)
);

// File: tb/sat_decide_ctrl_tb.sv
`timescale 1ns/1ps
module sat_decide_ctrl_tb_top;

  localparam int NUM_VARS = 16;
  localparam int LVL_W    = 5;
  localparam int VAR_W    = $clog2(NUM_VARS);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start_i;
  logic             impl_pend_i;
  logic             conflict_i;
  logic [LVL_W-1:0] bck_lvl_i;
  logic             done_o, sat_o, asg_valid_o, asg_val_o, asg_forced_o;
  logic [VAR_W-1:0] asg_var_o;
  logic [LVL_W-1:0] asg_lvl_o, clr_lvl_o;
  logic             refresh_o, clr_all_o, clr_above_o, ident_o, wr_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sat_decide_ctrl #(.NUM_VARS(NUM_VARS), .LVL_W(LVL_W)) dut_i (
    .clk, .rst_n, .start_i, .impl_pend_i, .conflict_i, .bck_lvl_i,
    .done_o, .sat_o, .asg_valid_o, .asg_var_o, .asg_lvl_o, .asg_val_o,
    .asg_forced_o, .refresh_o, .clr_all_o, .clr_above_o, .clr_lvl_o,
    .ident_o, .wr_o
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic quiet_outputs(input string req);
    chk({req, " done"}, int'(done_o), 0);
    chk({req, " asg_valid"}, int'(asg_valid_o), 0);
    chk({req, " refresh"}, int'(refresh_o), 0);
    chk({req, " clr_all"}, int'(clr_all_o), 0);
    chk({req, " clr_above"}, int'(clr_above_o), 0);
    chk({req, " ident"}, int'(ident_o), 0);
    chk({req, " wr"}, int'(wr_o), 0);
  endtask

  task automatic exp_asg(input string req, input int v, input int val, input int frc);
    chk({req, " asg_valid"}, int'(asg_valid_o), 1);
    chk({req, " asg_var"}, int'(asg_var_o), v);
    chk({req, " asg_lvl"}, int'(asg_lvl_o), v);
    chk({req, " asg_val"}, int'(asg_val_o), val);
    chk({req, " asg_forced"}, int'(asg_forced_o), frc);
  endtask

  // At an assignment cycle: check it, give a quiet wait, land on the next state.
  task automatic step_ok(input string req, input int v, input int val, input int frc);
    exp_asg(req, v, val, frc);
    cyc();
    impl_pend_i = 1'b0;
    conflict_i  = 1'b0;
    cyc();
  endtask

  // At an assignment cycle: check it, raise a conflict, walk analysis,
  // clear and precharge, land on the forced reassignment.
  task automatic step_conflict(input string req, input int v, input int val, input int frc,
                               input int bck, input int pend, input int exp_tgt);
    exp_asg(req, v, val, frc);
    cyc();
    conflict_i  = 1'b1;
    impl_pend_i = pend[0];
    bck_lvl_i   = LVL_W'(bck);
    cyc();
    chk("R6 ident", int'(ident_o), 1);
    chk("R6 wr", int'(wr_o), 1);
    chk("R6 no assign", int'(asg_valid_o), 0);
    conflict_i  = 1'b0;
    impl_pend_i = 1'b0;
    cyc();
    chk("R7 clr_above", int'(clr_above_o), 1);
    chk("R7 clr_lvl", int'(clr_lvl_o), exp_tgt);
    chk("R7 no refresh yet", int'(refresh_o), 0);
    cyc();
    chk("R8 precharge refresh", int'(refresh_o), 1);
    chk("R8 precharge no clr_all", int'(clr_all_o), 0);
    cyc();
    exp_asg("R8 forced reassign", exp_tgt, 1, 1);
  endtask

  task automatic t_reset();
    quiet_outputs("R1 reset");
    cyc();
    cyc();
    quiet_outputs("R1 idle");
  endtask

  task automatic t_sat_run();
    start_i = 1'b1;
    cyc();
    chk("R2 refresh", int'(refresh_o), 1);
    chk("R2 clr_all", int'(clr_all_o), 1);
    chk("R2 no assign", int'(asg_valid_o), 0);
    cyc();
    for (int k = 0; k < NUM_VARS; k++) begin
      exp_asg("R3 fresh", k, 0, 0);
      cyc();
      chk("R3 single cycle", int'(asg_valid_o), 0);
      if (k == 4) begin
        impl_pend_i = 1'b1;
        cyc();
        chk("R4 hold assign", int'(asg_valid_o), 0);
        chk("R4 hold done", int'(done_o), 0);
        cyc();
        chk("R4 hold assign 2", int'(asg_valid_o), 0);
        chk("R4 hold ident", int'(ident_o), 0);
        impl_pend_i = 1'b0;
      end
      cyc();
    end
    chk("R5 done", int'(done_o), 1);
    chk("R5 sat", int'(sat_o), 1);
    cyc();
    chk("R11 done one cycle", int'(done_o), 0);
    quiet_outputs("R11 hold");
    cyc();
    quiet_outputs("R11 hold 2");
    start_i = 1'b0;
    cyc();
    cyc();
    quiet_outputs("R11 back idle");
  endtask

  task automatic t_backtrack();
    start_i = 1'b1;
    cyc();
    chk("R2 refresh run2", int'(refresh_o), 1);
    cyc();
    for (int k = 0; k < 5; k++) step_ok("R3 run2", k, 0, 0);
    // Conflict wins over pending implications; target 3
    step_conflict("R3 lvl5", 5, 0, 0, 3, 1, 3);
    step_ok("R8 after", 3, 1, 1);
    step_ok("R9 lvl4 fresh", 4, 0, 0);
    // Plain chronological target 5
    step_conflict("R9 lvl5 fresh", 5, 0, 0, 5, 0, 5);
    // Level 5 already flipped: target skips down to 4
    step_conflict("R8 lvl5 forced", 5, 1, 1, 5, 0, 4);
    step_ok("R8 lvl4", 4, 1, 1);
    // Request above the current level is capped at the current level
    step_conflict("R9 lvl5 cleared", 5, 0, 0, 20, 0, 5);
    // Back to level 0
    step_conflict("R8 lvl5 again", 5, 1, 1, 0, 0, 0);
    step_ok("R8 lvl0", 0, 1, 1);
    step_ok("R9 lvl1", 1, 0, 0);
    step_ok("R9 lvl2", 2, 0, 0);
    step_ok("R9 lvl3 cleared", 3, 0, 0);
    // Level 4 was flipped before; the backtrack to 0 cleared it
    exp_asg("R9 lvl4 cleared", 4, 0, 0);
    cyc();
    conflict_i = 1'b1;
    bck_lvl_i  = '0;
    cyc();
    chk("R6 ident final", int'(ident_o), 1);
    conflict_i = 1'b0;
    cyc();
    chk("R10 done", int'(done_o), 1);
    chk("R10 unsat", int'(sat_o), 0);
    chk("R10 no clear", int'(clr_above_o), 0);
    cyc();
    chk("R11 done one cycle unsat", int'(done_o), 0);
    start_i = 1'b0;
    cyc();
    cyc();
    quiet_outputs("R11 idle after unsat");
    // New run starts with every flag cleared
    start_i = 1'b1;
    cyc();
    chk("R2 refresh run3", int'(refresh_o), 1);
    cyc();
    exp_asg("R11 fresh flags", 0, 0, 0);
    start_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    rst_n       = 1'b0;
    start_i     = 1'b0;
    impl_pend_i = 1'b0;
    conflict_i  = 1'b0;
    bck_lvl_i   = '0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_sat_run();
    t_backtrack();
    finish_run();
  end

endmodule